// File: doc/BRIEF.md
# Branch Divergence Stack

This block holds the control-flow reconvergence state for a group of SIMD threads. Each SIMD thread owns a private last-in, first-out stack. Each entry on that stack pairs an identifier token with a resume instruction address and a lane mask. The block also keeps one current active-lane mask per SIMD thread. Instruction fetch, decode and the lane datapaths sit outside this block.

The sequencer issues at most one command per cycle and names a SIMD thread with each command. A push records a new entry. A pop removes the top entry. An unwind discards entries down to and including the topmost entry whose token matches the command's token. A pop or an unwind produces a jump request one cycle later, carrying the removed entry's address and mask, and the same entry's mask becomes the thread's active mask. An illegal command leaves every stack and mask unchanged and sets an error flag that stays set.

A second, independent select brings out the depth and active mask of any SIMD thread. It also gates that mask with per-lane 1-bit predicates to form the lane enables.

Top module: `divstack_top`

## Requirements
- R1: After reset, every stack is empty (depth 0), every active mask is all ones, the error flag is 0 and no jump is requested.
- R2: A push (cmdOp = 1) on a stack that is not full stores the token, address and mask at the top of the addressed thread's stack. The depth rises by one one cycle later. No jump is requested and the active mask does not change.
- R3: A pop (cmdOp = 2) on a non-empty stack asserts jumpValid for exactly the following cycle. jumpPc and jumpMask carry the top entry's address and mask. In that same cycle the thread's active mask equals that mask and the depth is one lower.
- R4: Entries come back in the reverse of the order in which they were pushed.
- R5: Commands touch only the stack and active mask of the thread they name. Other threads keep their depth and mask.
- R6: An unwind (cmdOp = 3) searches for the topmost entry whose token equals cmdToken. It removes that entry and all entries above it, so the depth becomes that entry's index. One cycle later it requests a jump to that entry's address and loads that entry's mask as the active mask.
- R7: An unwind whose token is not in the addressed stack leaves the depth and the contents unchanged, requests no jump and sets the error flag.
- R8: A push on a full stack (depth = DEPTH) changes nothing and sets the error flag. The earlier entries stay intact.
- R9: A pop or an unwind on an empty stack requests no jump, leaves the depth at 0 and sets the error flag.
- R10: The error flag stays set through later legal commands until reset.
- R11: laneEnable equals the observed thread's active mask ANDed with predBits when predUse is 1, and equals the active mask when predUse is 0. It responds in the same cycle.
- R12: When cmdValid is 0, or when cmdOp = 0, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 2 | 0 none, 1 push, 2 pop, 3 unwind |
| cmdTid | input | TID_W | SIMD thread the command addresses |
| cmdToken | input | TOKEN_W | Token to push or to search for |
| cmdPc | input | PC_W | Address to push |
| cmdMask | input | LANES | Mask to push |
| obsTid | input | TID_W | SIMD thread whose state is shown |
| predUse | input | 1 | Apply predicates to the lane enables |
| predBits | input | LANES | Per-lane predicate bits |
| jumpValid | output | 1 | Jump request, one cycle after a pop or unwind |
| jumpPc | output | PC_W | Jump target address |
| jumpMask | output | LANES | Mask that came with the jump |
| obsDepth | output | SP_W | Stack depth of the observed thread |
| activeMask | output | LANES | Active mask of the observed thread |
| laneEnable | output | LANES | Active mask gated by the predicates |
| errFlag | output | 1 | Sticky illegal-command flag |

## Verification
The jump outputs, the depth and the active mask come from registers. Each result therefore appears in the cycle that follows the clock edge which accepts its command. laneEnable, activeMask and obsDepth are combinational functions of obsTid and the predicate inputs, so they follow those inputs in the same cycle. The bench changes inputs on the falling edge and lets exactly one rising edge pass. It reads the results at the next falling edge, which is the single cycle in which jumpValid is expected to be high.

// File: rtl/divstack_pkg.sv
package divstack_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_UNWIND = 2'd3
  } stackOp_e;

  typedef struct packed {
    logic doPush;
    logic doPop;
    logic doUnwind;
    logic raiseErr;
  } stackStrobe_t;

endpackage

// File: rtl/divstack_ctrl.sv
module divstack_ctrl
  import divstack_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic [SP_W-1:0] selDepth,
  input  logic            tokenHit,
  output stackStrobe_t    strb,
  output logic            errFlag
);

  logic isFull;
  logic isEmpty;
  stackOp_e opCode;

  assign isFull  = (selDepth == SP_W'(DEPTH));
  assign isEmpty = (selDepth == '0);
  assign opCode  = stackOp_e'(cmdOp);

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      unique case (opCode)
        OP_PUSH: begin
          if (isFull) strb.raiseErr = 1'b1;
          else        strb.doPush   = 1'b1;
        end
        OP_POP: begin
          if (isEmpty) strb.raiseErr = 1'b1;
          else         strb.doPop    = 1'b1;
        end
        OP_UNWIND: begin
          if (isEmpty || !tokenHit) strb.raiseErr = 1'b1;
          else                      strb.doUnwind = 1'b1;
        end
        default: strb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errFlag <= 1'b0;
    else if (strb.raiseErr) errFlag <= 1'b1;
  end

  // R10: once raised, the flag holds until reset
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R12: an idle command slot raises no strobe
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (strb == '0));

endmodule

// File: rtl/divstack_dp.sv
module divstack_dp
  import divstack_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int DEPTH       = 4,
  parameter int LANES       = 8,
  parameter int PC_W        = 16,
  parameter int TOKEN_W     = 4,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  stackStrobe_t       strb,
  input  logic [TID_W-1:0]   cmdTid,
  input  logic [TOKEN_W-1:0] cmdToken,
  input  logic [PC_W-1:0]    cmdPc,
  input  logic [LANES-1:0]   cmdMask,
  input  logic [TID_W-1:0]   obsTid,
  input  logic               predUse,
  input  logic [LANES-1:0]   predBits,
  output logic [SP_W-1:0]    selDepth,
  output logic               tokenHit,
  output logic               jumpValid,
  output logic [PC_W-1:0]    jumpPc,
  output logic [LANES-1:0]   jumpMask,
  output logic [SP_W-1:0]    obsDepth,
  output logic [LANES-1:0]   activeMask,
  output logic [LANES-1:0]   laneEnable
);

  logic [TOKEN_W-1:0] tokMem  [NUM_THREADS][DEPTH];
  logic [PC_W-1:0]    pcMem   [NUM_THREADS][DEPTH];
  logic [LANES-1:0]   maskMem [NUM_THREADS][DEPTH];
  logic [SP_W-1:0]    spArr   [NUM_THREADS];
  logic [LANES-1:0]   actMask [NUM_THREADS];

  logic [IDX_W-1:0] topIdx;
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] wrIdx;

  assign selDepth = spArr[cmdTid];
  assign topIdx   = IDX_W'(selDepth - SP_W'(1));
  assign wrIdx    = IDX_W'(selDepth);

  // topmost matching live entry wins: later iterations override earlier ones
  always_comb begin
    tokenHit = 1'b0;
    hitIdx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((SP_W'(i) < selDepth) && (tokMem[cmdTid][i] == cmdToken)) begin
        tokenHit = 1'b1;
        hitIdx   = IDX_W'(i);
      end
    end
  end

  // entry storage carries no reset: a slot is only read below the pointer
  always_ff @(posedge clk) begin
    if (strb.doPush) begin
      tokMem[cmdTid][wrIdx]  <= cmdToken;
      pcMem[cmdTid][wrIdx]   <= cmdPc;
      maskMem[cmdTid][wrIdx] <= cmdMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        spArr[t]   <= '0;
        actMask[t] <= '1;
      end
      jumpValid <= 1'b0;
      jumpPc    <= '0;
      jumpMask  <= '0;
    end else begin
      jumpValid <= 1'b0;
      if (strb.doPush) begin
        spArr[cmdTid] <= selDepth + SP_W'(1);
      end else if (strb.doPop) begin
        spArr[cmdTid]   <= selDepth - SP_W'(1);
        actMask[cmdTid] <= maskMem[cmdTid][topIdx];
        jumpValid       <= 1'b1;
        jumpPc          <= pcMem[cmdTid][topIdx];
        jumpMask        <= maskMem[cmdTid][topIdx];
      end else if (strb.doUnwind) begin
        spArr[cmdTid]   <= SP_W'(hitIdx);
        actMask[cmdTid] <= maskMem[cmdTid][hitIdx];
        jumpValid       <= 1'b1;
        jumpPc          <= pcMem[cmdTid][hitIdx];
        jumpMask        <= maskMem[cmdTid][hitIdx];
      end
    end
  end

  assign obsDepth   = spArr[obsTid];
  assign activeMask = actMask[obsTid];
  assign laneEnable = predUse ? (activeMask & predBits) : activeMask;

  // R8: no stack pointer ever passes the capacity
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_bound
    a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
      spArr[g] <= SP_W'(DEPTH));
  end

  // R2: an accepted push grows the addressed stack by one
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPush |=> (spArr[$past(cmdTid)] == SP_W'($past(selDepth) + SP_W'(1))));

  // R3: an accepted pop shrinks the addressed stack by one
  a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPop |=> (spArr[$past(cmdTid)] == SP_W'($past(selDepth) - SP_W'(1))));

  // R3/R6: a jump request only follows an accepted pop or unwind
  a_r3_jump_cause: assert property (@(posedge clk) disable iff (!rstN)
    jumpValid |-> $past(strb.doPop || strb.doUnwind));

  // R9: a rejected command never yields a jump
  a_r9_no_jump_on_err: assert property (@(posedge clk) disable iff (!rstN)
    strb.raiseErr |=> !jumpValid);

  // R6: an accepted unwind always has a matching entry
  a_r6_unwind_has_hit: assert property (@(posedge clk) disable iff (!rstN)
    strb.doUnwind |-> tokenHit);

endmodule

// File: rtl/divstack_top.sv
module divstack_top
  import divstack_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int DEPTH       = 4,
  parameter int LANES       = 8,
  parameter int PC_W        = 16,
  parameter int TOKEN_W     = 4,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdOp,
  input  logic [TID_W-1:0]   cmdTid,
  input  logic [TOKEN_W-1:0] cmdToken,
  input  logic [PC_W-1:0]    cmdPc,
  input  logic [LANES-1:0]   cmdMask,
  input  logic [TID_W-1:0]   obsTid,
  input  logic               predUse,
  input  logic [LANES-1:0]   predBits,
  output logic               jumpValid,
  output logic [PC_W-1:0]    jumpPc,
  output logic [LANES-1:0]   jumpMask,
  output logic [SP_W-1:0]    obsDepth,
  output logic [LANES-1:0]   activeMask,
  output logic [LANES-1:0]   laneEnable,
  output logic               errFlag
);

  stackStrobe_t    strb;
  logic [SP_W-1:0] selDepth;
  logic            tokenHit;

  divstack_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .selDepth (selDepth),
    .tokenHit (tokenHit),
    .strb     (strb),
    .errFlag  (errFlag)
  );

  divstack_dp #(
    .NUM_THREADS (NUM_THREADS),
    .DEPTH       (DEPTH),
    .LANES       (LANES),
    .PC_W        (PC_W),
    .TOKEN_W     (TOKEN_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmdTid     (cmdTid),
    .cmdToken   (cmdToken),
    .cmdPc      (cmdPc),
    .cmdMask    (cmdMask),
    .obsTid     (obsTid),
    .predUse    (predUse),
    .predBits   (predBits),
    .selDepth   (selDepth),
    .tokenHit   (tokenHit),
    .jumpValid  (jumpValid),
    .jumpPc     (jumpPc),
    .jumpMask   (jumpMask),
    .obsDepth   (obsDepth),
    .activeMask (activeMask),
    .laneEnable (laneEnable)
  );

endmodule

// File: tb/divstack_top_tb_top.sv
`timescale 1ns/1ps
module divstack_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [1:0]  cmdTid = 2'd0;
  logic [3:0]  cmdToken = 4'd0;
  logic [15:0] cmdPc = 16'd0;
  logic [7:0]  cmdMask = 8'd0;
  logic [1:0]  obsTid = 2'd0;
  logic        predUse = 1'b0;
  logic [7:0]  predBits = 8'd0;
  logic        jumpValid;
  logic [15:0] jumpPc;
  logic [7:0]  jumpMask;
  logic [2:0]  obsDepth;
  logic [7:0]  activeMask;
  logic [7:0]  laneEnable;
  logic        errFlag;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #2.5 clk = ~clk;

  divstack_top dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdTid(cmdTid),
    .cmdToken(cmdToken), .cmdPc(cmdPc), .cmdMask(cmdMask), .obsTid(obsTid),
    .predUse(predUse), .predBits(predBits), .jumpValid(jumpValid), .jumpPc(jumpPc),
    .jumpMask(jumpMask), .obsDepth(obsDepth), .activeMask(activeMask),
    .laneEnable(laneEnable), .errFlag(errFlag)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  tid;
    logic [3:0]  tok;
    logic [15:0] pc;
    logic [7:0]  mask;
    logic        expJv;
    logic [15:0] expPc;
    logic [7:0]  expMask;
    logic [2:0]  expDepth;
    logic [7:0]  expAct;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{2'd1, 2'd0, 4'd1, 16'h0100, 8'h0F, 1'b0, 16'h0000, 8'h00, 3'd1, 8'hFF},
    '{2'd1, 2'd0, 4'd2, 16'h0200, 8'h03, 1'b0, 16'h0000, 8'h00, 3'd2, 8'hFF},
    '{2'd1, 2'd0, 4'd3, 16'h0300, 8'h01, 1'b0, 16'h0000, 8'h00, 3'd3, 8'hFF},
    '{2'd1, 2'd1, 4'd5, 16'h0500, 8'hF0, 1'b0, 16'h0000, 8'h00, 3'd1, 8'hFF},
    '{2'd2, 2'd0, 4'd0, 16'h0000, 8'h00, 1'b1, 16'h0300, 8'h01, 3'd2, 8'h01},
    '{2'd1, 2'd0, 4'd4, 16'h0400, 8'h07, 1'b0, 16'h0000, 8'h00, 3'd3, 8'h01},
    '{2'd3, 2'd0, 4'd1, 16'h0000, 8'h00, 1'b1, 16'h0100, 8'h0F, 3'd0, 8'h0F},
    '{2'd2, 2'd1, 4'd0, 16'h0000, 8'h00, 1'b1, 16'h0500, 8'hF0, 3'd0, 8'hF0},
    '{2'd1, 2'd2, 4'd7, 16'h00A0, 8'h55, 1'b0, 16'h0000, 8'h00, 3'd1, 8'hFF},
    '{2'd1, 2'd2, 4'd7, 16'h00B0, 8'hAA, 1'b0, 16'h0000, 8'h00, 3'd2, 8'hFF},
    '{2'd3, 2'd2, 4'd7, 16'h0000, 8'h00, 1'b1, 16'h00B0, 8'hAA, 3'd1, 8'hAA},
    '{2'd2, 2'd2, 4'd0, 16'h0000, 8'h00, 1'b1, 16'h00A0, 8'h55, 3'd0, 8'h55}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive on a falling edge, let one rising edge pass, leave state visible
  task automatic doCmd(input logic v, input logic [1:0] op, input logic [1:0] tid,
                       input logic [3:0] tok, input logic [15:0] pc, input logic [7:0] m);
    @(negedge clk);
    cmdValid = v; cmdOp = op; cmdTid = tid; cmdToken = tok; cmdPc = pc; cmdMask = m;
    obsTid = tid;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cmdValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state, across every thread
    for (int t = 0; t < 4; t++) begin
      obsTid = 2'(t);
      #0.1;
      chk("R1 depth", 32'(obsDepth), 32'd0);
      chk("R1 mask", 32'(activeMask), 32'hFF);
    end
    chk("R1 err", 32'(errFlag), 32'd0);
    chk("R1 jump", 32'(jumpValid), 32'd0);

    // table: R2 push, R3 pop, R4 order, R5 per-thread, R6 unwind (topmost hit)
    for (int k = 0; k < NVEC; k++) begin
      doCmd(1'b1, VEC[k].op, VEC[k].tid, VEC[k].tok, VEC[k].pc, VEC[k].mask);
      chk("R2/R3/R6 jumpValid", 32'(jumpValid), 32'(VEC[k].expJv));
      if (VEC[k].expJv) begin
        chk("R3/R4/R6 jumpPc", 32'(jumpPc), 32'(VEC[k].expPc));
        chk("R3/R6 jumpMask", 32'(jumpMask), 32'(VEC[k].expMask));
      end
      chk("R2/R3/R6 depth", 32'(obsDepth), 32'(VEC[k].expDepth));
      chk("R5 activeMask", 32'(activeMask), 32'(VEC[k].expAct));
      chk("R2 no error", 32'(errFlag), 32'd0);
    end
    // R5: thread 1 kept its own mask after the thread 2 traffic
    obsTid = 2'd1; #0.1;
    chk("R5 other thread mask", 32'(activeMask), 32'hF0);

    // R11 predicate gating
    obsTid = 2'd2; predUse = 1'b1; predBits = 8'h0F; #0.1;
    chk("R11 gated", 32'(laneEnable), 32'h05);
    predUse = 1'b0; #0.1;
    chk("R11 ungated", 32'(laneEnable), 32'h55);
    obsTid = 2'd3; predUse = 1'b1; predBits = 8'h3C; #0.1;
    chk("R11 full mask", 32'(laneEnable), 32'h3C);
    predUse = 1'b0;

    // R12 an idle slot and a no-op code change nothing
    doCmd(1'b0, 2'd1, 2'd3, 4'd1, 16'h1234, 8'h11);
    chk("R12 idle depth", 32'(obsDepth), 32'd0);
    chk("R12 idle jump", 32'(jumpValid), 32'd0);
    doCmd(1'b1, 2'd0, 2'd3, 4'd1, 16'h1234, 8'h11);
    chk("R12 nop depth", 32'(obsDepth), 32'd0);
    chk("R12 nop err", 32'(errFlag), 32'd0);

    // R9 pop on an empty stack
    doCmd(1'b1, 2'd2, 2'd3, 4'd0, 16'h0, 8'h0);
    chk("R9 pop empty jump", 32'(jumpValid), 32'd0);
    chk("R9 pop empty depth", 32'(obsDepth), 32'd0);
    chk("R9 pop empty err", 32'(errFlag), 32'd1);
    // R10 sticky through a legal push
    doCmd(1'b1, 2'd1, 2'd3, 4'd2, 16'h0777, 8'h0C);
    chk("R10 sticky", 32'(errFlag), 32'd1);
    chk("R10 push still works", 32'(obsDepth), 32'd1);

    // R1 reset clears the flag; R9 unwind on an empty stack
    doReset();
    chk("R1 err cleared", 32'(errFlag), 32'd0);
    obsTid = 2'd0; #0.1;
    chk("R1 mask restored", 32'(activeMask), 32'hFF);
    doCmd(1'b1, 2'd3, 2'd0, 4'd1, 16'h0, 8'h0);
    chk("R9 unwind empty jump", 32'(jumpValid), 32'd0);
    chk("R9 unwind empty err", 32'(errFlag), 32'd1);

    // R7 unwind to a missing token
    doReset();
    for (int k = 1; k <= 4; k++)
      doCmd(1'b1, 2'd1, 2'd1, 4'(k), 16'(k * 16), 8'(k));
    doCmd(1'b1, 2'd3, 2'd1, 4'd9, 16'h0, 8'h0);
    chk("R7 missing jump", 32'(jumpValid), 32'd0);
    chk("R7 missing depth", 32'(obsDepth), 32'd4);
    chk("R7 missing err", 32'(errFlag), 32'd1);
    chk("R7 mask kept", 32'(activeMask), 32'hFF);
    doCmd(1'b1, 2'd2, 2'd1, 4'd0, 16'h0, 8'h0);
    chk("R7 contents kept", 32'(jumpPc), 32'h40);

    // R8 push on a full stack
    doReset();
    for (int k = 1; k <= 4; k++)
      doCmd(1'b1, 2'd1, 2'd1, 4'(k), 16'(k * 16), 8'(k));
    chk("R8 no err at capacity", 32'(errFlag), 32'd0);
    doCmd(1'b1, 2'd1, 2'd1, 4'd15, 16'hDEAD, 8'hEE);
    chk("R8 full err", 32'(errFlag), 32'd1);
    chk("R8 full depth", 32'(obsDepth), 32'd4);
    doCmd(1'b1, 2'd2, 2'd1, 4'd0, 16'h0, 8'h0);
    chk("R8 top intact pc", 32'(jumpPc), 32'h40);
    chk("R8 top intact mask", 32'(jumpMask), 32'h04);
    chk("R8 depth after pop", 32'(obsDepth), 32'd3);
    // R3 jump lasts exactly one cycle
    @(negedge clk);
    chk("R3 single-cycle jump", 32'(jumpValid), 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule